// File: doc/BRIEF.md
# LP-SDRAM Command Decoder with Mode Registers

This block sits on the memory side of a two-bank low-power SDRAM interface. On every rising clock edge it samples the clock-enable pin and compares it with its value at the previous edge. It also samples the chip select, the three strobe pins, the bank select and the address bus. From these it classifies the command, follows the device through its power states and keeps an open/idle bit for each bank. It also holds the base and extended mode registers. All outputs come from registers except the reserved-latency flag. The decoded command code and the illegal flag describe the edge that has just passed. The stored fields feed the burst, latency and drive logic elsewhere in the device.

The power state machine has six states. RUN is normal operation. PDN is power-down. SREF is self refresh. SUSP is clock suspend. DPD is deep power-down. WAKE is the first edge after leaving PDN, SREF or DPD. The transitions are:
- RUN goes to SREF on a refresh with CKE falling, to DPD on the burst-stop encoding with CKE falling, and to PDN or SUSP on a NOP with CKE falling.
- RUN goes to SUSP on any other command with CKE falling.
- PDN, SREF and DPD go to WAKE when CKE rises.
- WAKE goes to RUN after one edge.
- SUSP goes to RUN when CKE rises.

A mode-register load opens a blocking gap of MRS_GAP edges, during which any non-NOP command is rejected.

Top module: `lpsdr_cmd_decoder`

## Requirements
- R1: After reset the outputs are as follows: power state RUN (0), command code NOP (0), illegal low, both banks idle, both mode registers zero, and the reserved-latency flag high.
- R2: With CS# low and CKE high at both edges, the pins {RAS#,CAS#,WE#} decode as follows: 000 mode set, 001 refresh, 010 precharge, 011 activate, 101 read, 100 write, 110 burst stop, 111 NOP. CS# high reads as NOP. The command codes are NOP=0, MRS=2, EMRS=3, AREF=4, PRE=6, PREA=7, ACT=8, RD=9, RDA=10, WR=11, WRA=12 and BST=13.
- R3: A mode set with BA=0 stores A[9:0] in the base register and reports code 2. The base register holds burst length in [2:0], burst type in [3], CAS latency in [6:4], operating mode in [8:7] and write-burst mode in [9]. A mode set with BA=1 stores A[6:0] in the extended register and reports code 3. The extended register holds partial-array coverage in [2:0], temperature in [4:3] and drive strength in [6:5]. Each load leaves the other register unchanged.
- R4: The reserved-latency flag is high whenever the stored CAS latency is neither 010 nor 011.
- R5: Activate sets the open bit of bank BA. Activate to a bank that is already open is illegal. Precharge with A10 low clears bank BA and reports code 6. Precharge with A10 high clears both banks and reports code 7.
- R6: Read or write to an idle bank is illegal. With A10 high, a read or write reports RDA or WRA and leaves the bank idle.
- R7: A refresh with CKE high at both edges reports AREF (code 4) when all banks are idle. With any bank open it is illegal.
- R8: A refresh with CKE falling and all banks idle enters SREF (state 2) and reports code 5.
- R9: The burst-stop encoding with CKE falling enters DPD (state 4, code 14) only when all banks are idle. With any bank open it is illegal and the state stays RUN.
- R10: A NOP with CKE falling enters PDN (state 1, code 15) when all banks are idle, and SUSP (state 3, code 1) otherwise. Any other command on a falling CKE edge is executed and the state becomes SUSP. Commands in SUSP have no effect. CKE rising returns the block to RUN.
- R11: From PDN, SREF or DPD, the edge where CKE rises moves the block to WAKE (state 5). At the next edge a non-NOP command is illegal and is not executed, and the state becomes RUN.
- R12: A mode set while any bank is open is illegal. For the MRS_GAP edges after an accepted mode set, any non-NOP command is illegal and has no effect.
- R13: An illegal command pulses the illegal flag for one cycle, reports code NOP, and changes neither bank bits nor mode registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable as sampled at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address / opcode bus |
| cmd_code | output | 4 | Decoded command of the last edge |
| illegal | output | 1 | Last edge carried an illegal command |
| pwr_state | output | 3 | Power state (RUN 0, PDN 1, SREF 2, SUSP 3, DPD 4, WAKE 5) |
| bank_open | output | 2**BA_W | Open bit per bank |
| burst_len | output | 3 | Base register burst length |
| burst_type | output | 1 | Base register burst type |
| cas_lat | output | 3 | Base register CAS latency |
| op_mode | output | 2 | Base register operating mode |
| wr_single | output | 1 | Base register write-burst mode |
| pasr | output | 3 | Extended register array coverage |
| temp_sel | output | 2 | Extended register temperature setting |
| drive_sel | output | 2 | Extended register drive strength |
| cas_lat_rsvd | output | 1 | Stored CAS latency is a reserved code |

## Verification
Directed sequences walk each transition in turn. They separate the legal and illegal forms of every command by bank state, and they separate the four CKE-falling outcomes by command and bank occupancy. They also cover the exit through WAKE with and without a NOP, and the mode-register gap. A long seeded random run then mixes all eight strobe encodings, deselects, both banks, random opcodes and occasional CKE drops. Every output is compared each cycle against a bench-side model built from the requirements. This exposes ordering faults between low-power entry, the gap counter and bank tracking that the directed cases do not reach.

// File: rtl/lpsdr_pkg.sv
package lpsdr_pkg;

    // raw pin classification, before state and CKE are considered
    typedef enum logic [2:0] {
        RC_NOP, RC_MRS, RC_REF, RC_PRE, RC_ACT, RC_RD, RC_WR, RC_BST
    } raw_cmd_e;

    // reported command codes
    typedef enum logic [3:0] {
        C_NOP  = 4'd0,  C_SUSP = 4'd1,  C_MRS  = 4'd2,  C_EMRS = 4'd3,
        C_AREF = 4'd4,  C_SREF = 4'd5,  C_PRE  = 4'd6,  C_PREA = 4'd7,
        C_ACT  = 4'd8,  C_RD   = 4'd9,  C_RDA  = 4'd10, C_WR   = 4'd11,
        C_WRA  = 4'd12, C_BST  = 4'd13, C_DPD  = 4'd14, C_PDN  = 4'd15
    } cmd_e;

    typedef enum logic [2:0] {
        P_RUN  = 3'd0, P_PDN = 3'd1, P_SREF = 3'd2,
        P_SUSP = 3'd3, P_DPD = 3'd4, P_WAKE = 3'd5
    } pwr_e;

endpackage

// File: rtl/lpsdr_cmd_class.sv
module lpsdr_cmd_class
    import lpsdr_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output raw_cmd_e rc
);
    always_comb begin
        if (cs_n) begin
            rc = RC_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  rc = RC_MRS;
                3'b001:  rc = RC_REF;
                3'b010:  rc = RC_PRE;
                3'b011:  rc = RC_ACT;
                3'b101:  rc = RC_RD;
                3'b100:  rc = RC_WR;
                3'b110:  rc = RC_BST;
                default: rc = RC_NOP;
            endcase
        end
    end
endmodule

// File: rtl/lpsdr_mode_regs.sv
module lpsdr_mode_regs #(
    parameter int BASE_W = 10,
    parameter int EXT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_base,
    input  logic              ld_ext,
    input  logic [BASE_W-1:0] din,
    output logic [BASE_W-1:0] base_q,
    output logic [EXT_W-1:0]  ext_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ext_q  <= '0;
        end else begin
            if (ld_base) base_q <= din;
            if (ld_ext)  ext_q  <= din[EXT_W-1:0];
        end
    end

    // R3
    ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_base, ld_ext}));
    // R13
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_base) |-> $stable(base_q));
    // R13
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_ext) |-> $stable(ext_q));
endmodule

// File: rtl/lpsdr_bank_track.sv
module lpsdr_bank_track #(
    parameter int BA_W = 1,
    localparam int BANKS = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clr_one,
    input  logic             clr_all,
    input  logic [BA_W-1:0]  idx,
    output logic [BANKS-1:0] open_o
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic open_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                open_q <= 1'b0;
            else if (clr_all)
                open_q <= 1'b0;
            else if ((set || clr_one) && idx == BA_W'(g))
                open_q <= set;
        end
        assign open_o[g] = open_q;
    end

    // R5
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (open_o == '0));
endmodule

// File: rtl/lpsdr_cmd_decoder.sv
module lpsdr_cmd_decoder
    import lpsdr_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int BA_W    = 1,
    parameter int MRS_GAP = 2,
    localparam int BANKS  = 1 << BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_code,
    output logic              illegal,
    output logic [2:0]        pwr_state,
    output logic [BANKS-1:0]  bank_open,
    output logic [2:0]        burst_len,
    output logic              burst_type,
    output logic [2:0]        cas_lat,
    output logic [1:0]        op_mode,
    output logic              wr_single,
    output logic [2:0]        pasr,
    output logic [1:0]        temp_sel,
    output logic [1:0]        drive_sel,
    output logic              cas_lat_rsvd
);
    localparam int AP_BIT = 10;
    localparam int BASE_W = 10;
    localparam int EXT_W  = 7;
    localparam int CNT_W  = $clog2(MRS_GAP + 1);

    raw_cmd_e           rc;
    pwr_e               pwr_q, pwr_n;
    cmd_e               cmd_q, code_n, ex_code;
    logic               bad_q, bad_n, ex_bad, do_ex;
    logic               cke_q, cke_fall, cke_rise, all_idle;
    logic [CNT_W-1:0]   mrs_cnt, cnt_n;
    logic               ex_set, ex_clr1, ex_clra, ex_ldb, ex_lde, ex_mrs;
    logic [BASE_W-1:0]  base_q;
    logic [EXT_W-1:0]   ext_q;

    lpsdr_cmd_class u_class (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .rc(rc)
    );

    lpsdr_bank_track #(.BA_W(BA_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .set(do_ex & ex_set), .clr_one(do_ex & ex_clr1), .clr_all(do_ex & ex_clra),
        .idx(ba), .open_o(bank_open)
    );

    lpsdr_mode_regs #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_mregs (
        .clk(clk), .rst_n(rst_n),
        .ld_base(do_ex & ex_ldb), .ld_ext(do_ex & ex_lde),
        .din(addr[BASE_W-1:0]), .base_q(base_q), .ext_q(ext_q)
    );

    assign cke_fall = cke_q & ~cke;
    assign cke_rise = ~cke_q & cke;
    assign all_idle = (bank_open == '0);

    // effect of a command issued in normal operation
    always_comb begin
        ex_code = C_NOP;
        ex_bad  = 1'b0;
        ex_set  = 1'b0;
        ex_clr1 = 1'b0;
        ex_clra = 1'b0;
        ex_ldb  = 1'b0;
        ex_lde  = 1'b0;
        ex_mrs  = 1'b0;
        unique case (rc)
            RC_NOP: ex_code = C_NOP;
            RC_MRS: begin
                if (!all_idle) begin
                    ex_bad = 1'b1;
                end else begin
                    ex_mrs = 1'b1;
                    if (ba == '0) begin
                        ex_ldb  = 1'b1;
                        ex_code = C_MRS;
                    end else begin
                        ex_lde  = 1'b1;
                        ex_code = C_EMRS;
                    end
                end
            end
            RC_REF: begin
                if (!all_idle) ex_bad = 1'b1;
                else           ex_code = C_AREF;
            end
            RC_PRE: begin
                if (addr[AP_BIT]) begin
                    ex_clra = 1'b1;
                    ex_code = C_PREA;
                end else begin
                    ex_clr1 = 1'b1;
                    ex_code = C_PRE;
                end
            end
            RC_ACT: begin
                if (bank_open[ba]) begin
                    ex_bad = 1'b1;
                end else begin
                    ex_set  = 1'b1;
                    ex_code = C_ACT;
                end
            end
            RC_RD: begin
                if (!bank_open[ba]) begin
                    ex_bad = 1'b1;
                end else begin
                    ex_code = addr[AP_BIT] ? C_RDA : C_RD;
                    ex_clr1 = addr[AP_BIT];
                end
            end
            RC_WR: begin
                if (!bank_open[ba]) begin
                    ex_bad = 1'b1;
                end else begin
                    ex_code = addr[AP_BIT] ? C_WRA : C_WR;
                    ex_clr1 = addr[AP_BIT];
                end
            end
            RC_BST: ex_code = C_BST;
        endcase
        if (ex_bad) ex_code = C_NOP;
    end

    // power state transitions
    always_comb begin
        pwr_n  = pwr_q;
        code_n = C_NOP;
        bad_n  = 1'b0;
        do_ex  = 1'b0;
        cnt_n  = (mrs_cnt != '0) ? mrs_cnt - 1'b1 : '0;
        unique case (pwr_q)
            P_RUN: begin
                if (mrs_cnt != '0) begin
                    bad_n = (rc != RC_NOP);
                end else if (cke_fall) begin
                    unique case (rc)
                        RC_REF: begin
                            if (all_idle) begin
                                pwr_n  = P_SREF;
                                code_n = C_SREF;
                            end else bad_n = 1'b1;
                        end
                        RC_BST: begin
                            if (all_idle) begin
                                pwr_n  = P_DPD;
                                code_n = C_DPD;
                            end else bad_n = 1'b1;
                        end
                        RC_NOP: begin
                            pwr_n  = all_idle ? P_PDN : P_SUSP;
                            code_n = all_idle ? C_PDN : C_SUSP;
                        end
                        default: begin
                            do_ex = 1'b1;
                            pwr_n = P_SUSP;
                        end
                    endcase
                end else begin
                    do_ex = 1'b1;
                end
            end
            P_PDN, P_SREF, P_DPD: if (cke_rise) pwr_n = P_WAKE;
            P_SUSP:               if (cke_rise) pwr_n = P_RUN;
            P_WAKE: begin
                bad_n = (rc != RC_NOP);
                pwr_n = P_RUN;
            end
            default: pwr_n = P_RUN;
        endcase
        if (do_ex) begin
            code_n = ex_code;
            bad_n  = ex_bad;
            if (ex_mrs) cnt_n = CNT_W'(MRS_GAP);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q   <= P_RUN;
            cke_q   <= 1'b1;
            mrs_cnt <= '0;
        end else begin
            pwr_q   <= pwr_n;
            cke_q   <= cke;
            mrs_cnt <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= C_NOP;
            bad_q <= 1'b0;
        end else begin
            cmd_q <= code_n;
            bad_q <= bad_n;
        end
    end

    assign cmd_code     = cmd_q;
    assign illegal      = bad_q;
    assign pwr_state    = pwr_q;
    assign burst_len    = base_q[2:0];
    assign burst_type   = base_q[3];
    assign cas_lat      = base_q[6:4];
    assign op_mode      = base_q[8:7];
    assign wr_single    = base_q[9];
    assign pasr         = ext_q[2:0];
    assign temp_sel     = ext_q[4:3];
    assign drive_sel    = ext_q[6:5];
    assign cas_lat_rsvd = !(cas_lat == 3'd2 || cas_lat == 3'd3);

    // R9
    dpd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == P_DPD && $past(pwr_q) != P_DPD) |-> ($past(bank_open) == '0));
    // R11
    wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pwr_q) == P_PDN || $past(pwr_q) == P_SREF || $past(pwr_q) == P_DPD)
         && pwr_q != $past(pwr_q)) |-> (pwr_q == P_WAKE));
    // R12
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_q) == C_MRS || $past(cmd_q) == C_EMRS) |-> (cmd_q == C_NOP));
    // R13
    bad_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> $stable(bank_open));
endmodule

// File: tb/lpsdr_cmd_decoder_bench.sv
module lpsdr_cmd_decoder_bench;
    localparam bit [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010, K_ACT = 3'b011;
    localparam bit [2:0] K_WR  = 3'b100, K_RD  = 3'b101, K_BST = 3'b110, K_NOP = 3'b111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n;
    logic [0:0]  ba;
    logic [10:0] addr;
    logic [3:0]  cmd_code;
    logic        illegal, burst_type, wr_single, cas_lat_rsvd;
    logic [2:0]  pwr_state, burst_len, cas_lat, pasr;
    logic [1:0]  bank_open, op_mode, temp_sel, drive_sel;

    lpsdr_cmd_decoder u_lpsdr_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_code(cmd_code), .illegal(illegal), .pwr_state(pwr_state),
        .bank_open(bank_open), .burst_len(burst_len), .burst_type(burst_type),
        .cas_lat(cas_lat), .op_mode(op_mode), .wr_single(wr_single),
        .pasr(pasr), .temp_sel(temp_sel), .drive_sel(drive_sel),
        .cas_lat_rsvd(cas_lat_rsvd)
    );

    always #10 clk = ~clk;

    int n_tests = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    // bench model of the requirements
    int       m_st, m_cnt, m_code;
    bit       m_bad, m_ckeq;
    bit [1:0] m_open;
    bit [9:0] m_base;
    bit [6:0] m_ext;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_exec(input int rc, input bit idle);
        case (rc)
            K_MRS: if (!idle) m_bad = 1; else begin
                m_cnt = 2;
                if (ba == 0) begin m_base = addr[9:0]; m_code = 2; end
                else begin m_ext = addr[6:0]; m_code = 3; end
            end
            K_REF: if (!idle) m_bad = 1; else m_code = 4;
            K_PRE: if (addr[10]) begin m_open = 0; m_code = 7; end
                   else begin m_open[ba] = 0; m_code = 6; end
            K_ACT: if (m_open[ba]) m_bad = 1; else begin m_open[ba] = 1; m_code = 8; end
            K_RD:  if (!m_open[ba]) m_bad = 1; else begin
                       m_code = addr[10] ? 10 : 9; if (addr[10]) m_open[ba] = 0; end
            K_WR:  if (!m_open[ba]) m_bad = 1; else begin
                       m_code = addr[10] ? 12 : 11; if (addr[10]) m_open[ba] = 0; end
            K_BST: m_code = 13;
            default: m_code = 0;
        endcase
    endtask

    task automatic model_step();
        int rc, c0;
        bit fall, rise, idle, ex;
        rc   = cs_n ? int'(K_NOP) : int'({ras_n, cas_n, we_n});
        fall = m_ckeq && !cke;
        rise = !m_ckeq && cke;
        idle = (m_open == 0);
        m_code = 0; m_bad = 0; ex = 0;
        c0 = m_cnt;
        if (m_cnt > 0) m_cnt--;
        case (m_st)
            0: if (c0 != 0) m_bad = (rc != K_NOP);
               else if (fall) begin
                   if (rc == K_REF) begin
                       if (idle) begin m_st = 2; m_code = 5; end else m_bad = 1;
                   end else if (rc == K_BST) begin
                       if (idle) begin m_st = 4; m_code = 14; end else m_bad = 1;
                   end else if (rc == K_NOP) begin
                       m_st = idle ? 1 : 3; m_code = idle ? 15 : 1;
                   end else begin ex = 1; m_st = 3; end
               end else ex = 1;
            1, 2, 4: if (rise) m_st = 5;
            3: if (rise) m_st = 0;
            5: begin m_bad = (rc != K_NOP); m_st = 0; end
            default: m_st = 0;
        endcase
        if (ex) model_exec(rc, idle);
        if (m_bad) m_code = 0;
        m_ckeq = cke;
    endtask

    task automatic compare_all();
        chk("R2",  "cmd_code",  cmd_code, m_code);
        chk("R13", "illegal",   illegal, m_bad);
        chk("R10", "pwr_state", pwr_state, m_st);
        chk("R5",  "bank_open", bank_open, m_open);
        chk("R3",  "base_reg",  {wr_single, op_mode, cas_lat, burst_type, burst_len}, m_base);
        chk("R3",  "ext_reg",   {drive_sel, temp_sel, pasr}, m_ext);
        chk("R4",  "cl_rsvd",   cas_lat_rsvd, !(m_base[6:4] == 2 || m_base[6:4] == 3));
    endtask

    // drive at a falling edge, then compare at the next falling edge
    task automatic drive(input bit k, input bit cs, input bit [2:0] c, input bit b, input bit [10:0] a);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = K_NOP; ba = 0; addr = 0;
        m_st = 0; m_cnt = 0; m_code = 0; m_bad = 0; m_ckeq = 1;
        m_open = 0; m_base = 0; m_ext = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "pwr_state", pwr_state, 0);
        chk("R1", "cmd_code",  cmd_code, 0);
        chk("R1", "illegal",   illegal, 0);
        chk("R1", "bank_open", bank_open, 0);
        chk("R1", "cl_rsvd",   cas_lat_rsvd, 1);

        drive(1, 0, K_RD, 0, 0);
        chk("R6", "read idle bank illegal", illegal, 1);
        drive(1, 0, K_MRS, 0, {1'b0, 1'b0, 2'b00, 3'b011, 1'b1, 3'b010});
        chk("R3", "cas_lat", cas_lat, 3);
        chk("R4", "cl_rsvd after CL3", cas_lat_rsvd, 0);
        drive(1, 0, K_ACT, 0, 0);
        chk("R12", "act in gap illegal", illegal, 1);
        chk("R12", "act in gap ignored", bank_open, 0);
        drive(1, 1, K_NOP, 0, 0);
        drive(1, 0, K_ACT, 0, 11'h123);
        chk("R5", "act bank0", bank_open, 2'b01);
        drive(1, 0, K_MRS, 1, 0);
        chk("R12", "mrs with open bank", illegal, 1);
        drive(1, 0, K_RD, 0, 11'h400);
        chk("R6", "read auto precharge code", cmd_code, 10);
        chk("R6", "read auto precharge closes", bank_open, 0);
        drive(1, 0, K_ACT, 1, 0);
        drive(1, 0, K_ACT, 1, 0);
        chk("R5", "double act illegal", illegal, 1);
        drive(1, 0, K_REF, 0, 0);
        chk("R7", "refresh with open bank", illegal, 1);
        drive(1, 0, K_PRE, 0, 11'h400);
        chk("R5", "precharge all", cmd_code, 7);
        drive(1, 0, K_REF, 0, 0);
        chk("R7", "auto refresh", cmd_code, 4);
        drive(0, 0, K_REF, 0, 0);
        chk("R8", "self refresh entry", pwr_state, 2);
        drive(0, 0, K_ACT, 0, 0);
        drive(1, 1, K_NOP, 0, 0);
        chk("R11", "wake after self refresh", pwr_state, 5);
        drive(1, 0, K_ACT, 0, 0);
        chk("R11", "non-NOP on wake edge", illegal, 1);
        chk("R11", "back to run", pwr_state, 0);
        drive(0, 1, K_NOP, 0, 0);
        chk("R10", "power down entry", pwr_state, 1);
        drive(1, 1, K_NOP, 0, 0);
        drive(1, 1, K_NOP, 0, 0);
        drive(1, 0, K_ACT, 0, 0);
        drive(0, 1, K_NOP, 0, 0);
        chk("R10", "clock suspend entry", cmd_code, 1);
        drive(0, 0, K_ACT, 1, 0);
        chk("R10", "act ignored in suspend", bank_open, 2'b01);
        drive(1, 1, K_NOP, 0, 0);
        chk("R10", "suspend exit", pwr_state, 0);
        drive(0, 0, K_BST, 0, 0);
        chk("R9", "deep power down with open bank", illegal, 1);
        chk("R9", "stays run", pwr_state, 0);
        drive(1, 0, K_PRE, 0, 0);
        chk("R5", "precharge one bank", cmd_code, 6);
        drive(0, 0, K_BST, 0, 0);
        chk("R9", "deep power down entry", pwr_state, 4);
        drive(1, 1, K_NOP, 0, 0);
        drive(1, 1, K_NOP, 0, 0);
        drive(1, 0, K_MRS, 1, {4'b0, 2'b10, 2'b01, 3'b101});
        chk("R3", "ext drive", drive_sel, 2);
        chk("R3", "ext pasr", pasr, 5);
        chk("R3", "base kept", cas_lat, 3);

        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
                  3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 11'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule